// File: doc/BRIEF.md
# FIFO-Driven DMA Flow Controller

This block sits between a backend FIFO that is being drained and the flow-control inputs of a bus core. The core can act either as a bus target or as a DMA master. The block takes the FIFO fill level and derives an empty flag and a low-water flag from it. From these flags it drives the core's busy and retry request, its read strobe, its DMA start inhibit and its DMA stop request. The result is that FIFO contents move to host memory without any software involvement.

In master mode the block follows each DMA cycle from the start pulse to the done pulse. A cycle is asked to stop as soon as the level reaches the low-water threshold. After the stop request, the block still allows a bounded number of trailing reads. The threshold is chosen to be no smaller than that bound, so that every trailing read still finds a word in the FIFO. When a cycle has been stopped early, the block remembers this. Once data arrives again, it raises a restart hint and releases the start inhibit. A read that arrives while the FIFO is empty never pops the FIFO and is reported as an underflow.

Top module: `fifo_dma_flow`

## Requirements
- R1: With `mode_master` low, `tgt_busy` is high in exactly the cycles where `fifo_level` is 0. With `mode_master` high, `tgt_busy` is always low.
- R2: `rd_stb` is high exactly when `fifo_level` is nonzero, in either mode.
- R3: With `mode_master` high, `rd_busy_mst` equals (`fifo_level` == 0). With `mode_master` low it stays low. `wr_busy_mst` is always low.
- R4: Suppose the block is idle in master mode, `dma_go` is high and `fifo_level` is nonzero. Then `dma_active` is high from the next cycle on. A `dma_go` that arrives while the level is 0, or while a cycle is already active, has no effect.
- R5: During an active cycle in master mode, `stop_master` goes high in any cycle where `fifo_level` <= AE_THRESH (default 4). From then on it stays high until `dma_done`. After `dma_done`, `dma_active` is low from the next cycle.
- R6: `fifo_pop` equals `core_rd` AND (`fifo_level` != 0) in the same cycle. A `core_rd` that arrives with `fifo_level` 0 raises `underflow` for exactly the next cycle.
- R7: Reads made while `stop_master` is high count as trailing reads, and MAX_TRAIL of them (default 3) are allowed per cycle. Each read beyond that limit still pops the FIFO if it holds data, and it raises `trail_err` for the next cycle.
- R8: When a cycle ends with `stop_master` high, a resume flag is set. While the block is idle in master mode with that flag set, `dma_kick` is high whenever `fifo_level` is nonzero. The flag clears when a `dma_go` is accepted.
- R9: One cycle after `mode_master` is low, `dma_active`, `stop_master` and `dma_kick` are all low and the resume flag is cleared.
- R10: While reset is held, and until the first stimulus after it, `dma_active`, `underflow`, `trail_err` and `dma_kick` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_master | input | 1 | 1 = DMA master path, 0 = target path |
| fifo_level | input | LVL_W | Current FIFO occupancy in words |
| core_rd | input | 1 | Core reads one word this cycle |
| dma_go | input | 1 | Core requests the start of a DMA cycle |
| dma_done | input | 1 | Core reports the end of the current DMA cycle |
| tgt_busy | output | 1 | Busy/retry request for target transfers |
| rd_stb | output | 1 | Data-available strobe toward the core |
| fifo_pop | output | 1 | Pop one word from the FIFO |
| rd_busy_mst | output | 1 | Inhibits the start of a DMA read cycle |
| wr_busy_mst | output | 1 | Write-side inhibit, held low |
| stop_master | output | 1 | Requests early end of the DMA cycle |
| dma_active | output | 1 | A DMA cycle is in progress |
| dma_kick | output | 1 | Restart hint after an early stop |
| underflow | output | 1 | Pulse: read attempted on empty FIFO |
| trail_err | output | 1 | Pulse: trailing-read budget exceeded |

## Verification
The hardest state to reach is the one where the trailing-read budget is exceeded while the FIFO still holds data. Reaching it needs a master cycle that is started on a well-filled FIFO and drained into the low-water band. The core model then keeps issuing reads, one per cycle, after the stop request. The bench does this by pushing ten words and starting a cycle. It then reads continuously, past the stop point and through the empty point, so that the over-budget read, the last valid pop and the underflow all occur in order. A refill then checks the restart hint, and a mode switch in the middle of a cycle checks that the cycle is abandoned cleanly.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE = 2'd0,
    CYC_RUN  = 2'd1,
    CYC_STOP = 2'd2
  } cyc_state_t;
endpackage

// File: rtl/fdc_rst_sync.sv
module fdc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign srst_n = hold_q;
endmodule

// File: rtl/fdc_level_decode.sv
module fdc_level_decode #(
  parameter int LVL_W     = 6,
  parameter int AE_THRESH = 4
) (
  input  logic [LVL_W-1:0] level,
  output logic             is_empty,
  output logic             is_low
);
  localparam logic [LVL_W-1:0] LOW_MARK = LVL_W'(AE_THRESH);

  always_comb begin
    is_empty = (level == '0);
    is_low   = (level <= LOW_MARK);
  end
endmodule

// File: rtl/fdc_read_gate.sv
module fdc_read_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic master,
  input  logic is_empty,
  input  logic core_rd,
  output logic tgt_busy,
  output logic rd_stb,
  output logic fifo_pop,
  output logic rd_busy_mst,
  output logic wr_busy_mst,
  output logic underflow
);
  logic uf_d;
  logic uf_q;

  always_comb begin
    tgt_busy    = !master && is_empty;
    rd_busy_mst = master && is_empty;
    wr_busy_mst = 1'b0;
    rd_stb      = !is_empty;
    fifo_pop    = core_rd && !is_empty;
    uf_d        = core_rd && is_empty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uf_q <= 1'b0;
    else        uf_q <= uf_d;
  end

  assign underflow = uf_q;
endmodule

// File: rtl/fdc_cycle_fsm.sv
module fdc_cycle_fsm
  import fdc_pkg::*;
#(
  parameter int MAX_TRAIL = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master,
  input  logic is_empty,
  input  logic is_low,
  input  logic core_rd,
  input  logic dma_go,
  input  logic dma_done,
  output logic dma_active,
  output logic stop_req,
  output logic kick,
  output logic trail_err
);
  localparam int CNT_W = $clog2(MAX_TRAIL + 1);
  localparam logic [CNT_W-1:0] TRAIL_LIM = CNT_W'(MAX_TRAIL);

  cyc_state_t       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             res_q, res_d;
  logic             te_q, te_d;
  logic             cnt_en;

  always_comb begin
    st_d     = st_q;
    res_d    = res_q;
    stop_req = master && ((st_q == CYC_STOP) || ((st_q == CYC_RUN) && is_low));
    if (!master) begin
      st_d  = CYC_IDLE;
      res_d = 1'b0;
    end else begin
      case (st_q)
        CYC_IDLE: begin
          if (dma_go && !is_empty) begin
            st_d  = CYC_RUN;
            res_d = 1'b0;
          end
        end
        CYC_RUN: begin
          if (dma_done) begin
            st_d  = CYC_IDLE;
            res_d = stop_req;
          end else if (is_low) begin
            st_d = CYC_STOP;
          end
        end
        CYC_STOP: begin
          if (dma_done) begin
            st_d  = CYC_IDLE;
            res_d = 1'b1;
          end
        end
        default: st_d = CYC_IDLE;
      endcase
    end
  end

  always_comb begin
    cnt_en = stop_req && core_rd && (cnt_q != TRAIL_LIM);
    cnt_d  = cnt_q;
    if (st_d == CYC_IDLE)  cnt_d = '0;
    else if (cnt_en)       cnt_d = cnt_q + 1'b1;
    te_d = stop_req && core_rd && (cnt_q == TRAIL_LIM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CYC_IDLE;
      cnt_q <= '0;
      res_q <= 1'b0;
      te_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      res_q <= res_d;
      te_q  <= te_d;
    end
  end

  always_comb begin
    dma_active = (st_q != CYC_IDLE);
    kick       = master && (st_q == CYC_IDLE) && res_q && !is_empty;
    trail_err  = te_q;
  end
endmodule

// File: rtl/fifo_dma_flow.sv
module fifo_dma_flow #(
  parameter int LVL_W     = 6,
  parameter int AE_THRESH = 4,
  parameter int MAX_TRAIL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_master,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             core_rd,
  input  logic             dma_go,
  input  logic             dma_done,
  output logic             tgt_busy,
  output logic             rd_stb,
  output logic             fifo_pop,
  output logic             rd_busy_mst,
  output logic             wr_busy_mst,
  output logic             stop_master,
  output logic             dma_active,
  output logic             dma_kick,
  output logic             underflow,
  output logic             trail_err
);
  logic rst_sync_n;
  logic is_empty;
  logic is_low;

  fdc_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  fdc_level_decode #(
    .LVL_W     (LVL_W),
    .AE_THRESH (AE_THRESH)
  ) u_lvl (
    .level    (fifo_level),
    .is_empty (is_empty),
    .is_low   (is_low)
  );

  fdc_read_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .master      (mode_master),
    .is_empty    (is_empty),
    .core_rd     (core_rd),
    .tgt_busy    (tgt_busy),
    .rd_stb      (rd_stb),
    .fifo_pop    (fifo_pop),
    .rd_busy_mst (rd_busy_mst),
    .wr_busy_mst (wr_busy_mst),
    .underflow   (underflow)
  );

  fdc_cycle_fsm #(
    .MAX_TRAIL (MAX_TRAIL)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .master     (mode_master),
    .is_empty   (is_empty),
    .is_low     (is_low),
    .core_rd    (core_rd),
    .dma_go     (dma_go),
    .dma_done   (dma_done),
    .dma_active (dma_active),
    .stop_req   (stop_master),
    .kick       (dma_kick),
    .trail_err  (trail_err)
  );
endmodule

// File: rtl/fifo_dma_flow_chk.sv
module fifo_dma_flow_chk #(
  parameter int LVL_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_master,
  input logic [LVL_W-1:0] fifo_level,
  input logic             core_rd,
  input logic             dma_done,
  input logic             tgt_busy,
  input logic             rd_stb,
  input logic             fifo_pop,
  input logic             stop_master,
  input logic             dma_active,
  input logic             dma_kick,
  input logic             underflow
);
  // R1
  tgt_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_master && fifo_level == '0) |-> tgt_busy);

  // R2
  rd_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> (fifo_level != '0));

  // R6
  no_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (fifo_level != '0));

  // R6
  underflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rd && fifo_level == '0) |=> underflow);

  // R5
  stop_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_master |-> dma_active);

  // R5
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_master && !dma_done) |=> (stop_master || !mode_master));

  // R9
  target_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_master |=> (!dma_active && !dma_kick));
endmodule

bind fifo_dma_flow fifo_dma_flow_chk #(.LVL_W(LVL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .mode_master (mode_master),
  .fifo_level  (fifo_level),
  .core_rd     (core_rd),
  .dma_done    (dma_done),
  .tgt_busy    (tgt_busy),
  .rd_stb      (rd_stb),
  .fifo_pop    (fifo_pop),
  .stop_master (stop_master),
  .dma_active  (dma_active),
  .dma_kick    (dma_kick),
  .underflow   (underflow)
);

// File: tb/tb_fifo_dma_flow.sv
`timescale 1ns/1ps
module tb_fifo_dma_flow;
  localparam int LVL_W = 6;
  localparam int AE    = 4;
  localparam int MAXT  = 3;

  logic             clk;
  logic             rst_n;
  logic             mode_master;
  logic [LVL_W-1:0] fifo_level;
  logic             core_rd, dma_go, dma_done;
  logic tgt_busy, rd_stb, fifo_pop, rd_busy_mst, wr_busy_mst;
  logic stop_master, dma_active, dma_kick, underflow, trail_err;

  int n_cmp = 0;
  int n_bad = 0;
  int fifo_q[$];
  int wr_tag = 0;

  // reference state
  int m_st = 0;   // 0 idle, 1 running, 2 stopping
  int m_cnt = 0;
  bit m_res = 0;
  bit m_uf = 0;
  bit m_te = 0;

  fifo_dma_flow #(.LVL_W(LVL_W), .AE_THRESH(AE), .MAX_TRAIL(MAXT)) dut (
    .clk(clk), .rst_n(rst_n), .mode_master(mode_master), .fifo_level(fifo_level),
    .core_rd(core_rd), .dma_go(dma_go), .dma_done(dma_done),
    .tgt_busy(tgt_busy), .rd_stb(rd_stb), .fifo_pop(fifo_pop),
    .rd_busy_mst(rd_busy_mst), .wr_busy_mst(wr_busy_mst), .stop_master(stop_master),
    .dma_active(dma_active), .dma_kick(dma_kick), .underflow(underflow),
    .trail_err(trail_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic compare_all();
    bit emp, low, stp;
    emp = (fifo_q.size() == 0);
    low = (fifo_q.size() <= AE);
    stp = mode_master && ((m_st == 2) || (m_st == 1 && low));
    chk("R1 tgt_busy", tgt_busy, !mode_master && emp);
    chk("R2 rd_stb", rd_stb, !emp);
    chk("R3 rd_busy_mst", rd_busy_mst, mode_master && emp);
    chk("R3 wr_busy_mst", wr_busy_mst, 1'b0);
    chk("R4 dma_active", dma_active, m_st != 0);
    chk("R5 stop_master", stop_master, stp);
    chk("R6 fifo_pop", fifo_pop, core_rd && !emp);
    chk("R6 underflow", underflow, m_uf);
    chk("R7 trail_err", trail_err, m_te);
    chk("R8 dma_kick", dma_kick, mode_master && m_st == 0 && m_res && !emp);
  endtask

  task automatic model_edge(input int push);
    bit emp, low, stp, to_idle;
    emp = (fifo_q.size() == 0);
    low = (fifo_q.size() <= AE);
    stp = mode_master && ((m_st == 2) || (m_st == 1 && low));
    m_uf = core_rd && emp;
    m_te = stp && core_rd && (m_cnt >= MAXT);
    to_idle = 0;
    if (!mode_master) begin
      m_st = 0; m_res = 0; to_idle = 1;
    end else if (m_st == 0) begin
      if (dma_go && !emp) begin m_st = 1; m_res = 0; end
      else to_idle = 1;
    end else if (dma_done) begin
      m_res = (m_st == 2) ? 1'b1 : stp;
      m_st = 0; to_idle = 1;
    end else begin
      if (m_st == 1 && low) m_st = 2;
      if (stp && core_rd && m_cnt < MAXT) m_cnt++;
    end
    if (to_idle) m_cnt = 0;
    if (core_rd && !emp) void'(fifo_q.pop_front());
    for (int i = 0; i < push; i++) begin
      fifo_q.push_back(wr_tag);
      wr_tag++;
    end
  endtask

  // drive at the falling edge, compare, then advance the model at the rising edge
  task automatic step(input logic rd, input logic go, input logic done,
                      input logic mst, input int push);
    core_rd = rd; dma_go = go; dma_done = done; mode_master = mst;
    fifo_level = LVL_W'(fifo_q.size());
    #1;
    compare_all();
    @(posedge clk);
    model_edge(push);
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 20000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; mode_master = 1'b0; fifo_level = '0;
    core_rd = 1'b0; dma_go = 1'b0; dma_done = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 dma_active", dma_active, 1'b0);
    chk("R10 underflow", underflow, 1'b0);
    chk("R10 trail_err", trail_err, 1'b0);
    chk("R10 dma_kick", dma_kick, 1'b0);
    rst_n = 1'b1;
    repeat (4) step(0, 0, 0, 0, 0);
    // R1/R6: target mode, empty FIFO, read attempt flagged
    step(1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 5);
    step(1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    repeat (3) step(1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    // R4: go on empty FIFO ignored
    step(0, 1, 0, 1, 0);
    step(0, 0, 0, 1, 10);
    // R4/R5/R7: start, drain past the low mark and beyond the trailing budget
    step(0, 1, 0, 1, 0);
    step(0, 1, 0, 1, 0);
    for (int i = 0; i < 11; i++) step(1, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0);
    // R5/R8: end of a stopped cycle, then refill raises the restart hint
    step(0, 0, 1, 1, 0);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 8);
    step(0, 0, 0, 1, 0);
    step(0, 1, 0, 1, 0);
    step(1, 0, 0, 1, 0);
    step(0, 0, 1, 1, 0);
    step(0, 0, 0, 1, 0);
    // R9: switch to target mode during a cycle
    step(0, 1, 0, 1, 0);
    step(1, 0, 0, 1, 0);
    for (int i = 0; i < 3; i++) step(1, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0);
    step(1, 0, 0, 0, 0);
    repeat (2) step(0, 0, 0, 0, 0);
    finish_run();
  end
endmodule